// File: doc/BRIEF.md
# Memory-mapped console I/O controller

This block is a bus-slave peripheral that gives a processor one character input channel and one character output channel through four word registers placed at the bottom of a fixed address window. The input side captures each incoming byte from a byte-valid stream and raises a ready flag. It drives an interrupt line while a byte waits and software has enabled that interrupt. Reading the input data register consumes the byte and clears the flag.

The output side accepts a byte written by the processor and emits it on a one-cycle output strobe. It then reports busy for a configurable number of cycles. Software polls the output ready flag before each write. A write made while the channel is busy is dropped. The bus is single-cycle: a read returns data combinationally in the cycle the select is high, and a write takes effect at the next clock edge.

Top module: `console_io_ctrl`

## Requirements
- R1: After reset, input ready (bit 0 at offset 0x0) is 0, interrupt enable (bit 1 at offset 0x0) is 0, output ready (bit 0 at offset 0x8) is 1, `irq` is 0 and `tx_valid` is 0.
- R2: A cycle with `rx_valid` high stores `rx_byte`. From the next cycle the byte reads back in bits 7:0 of offset 0x4, with upper bits zero, and input ready reads 1.
- R3: A read of offset 0x4 clears input ready from the next cycle. If a byte arrives in the same cycle as that read, the arrival wins and ready stays 1.
- R4: A byte arriving while input ready is already 1 replaces the stored byte, and ready stays 1.
- R5: Bit 1 of offset 0x0 is read/write. Bit 0 of offset 0x0 ignores writes. `irq` is 1 exactly while input ready and the enable are both 1.
- R6: A write to offset 0xC while output ready is 1 makes `tx_valid` high for exactly the next cycle, with `tx_byte` equal to bits 7:0 of the written word.
- R7: After an accepted output write, output ready reads 0 for exactly TX_BUSY_CYCLES cycles and then reads 1.
- R8: A write to offset 0xC while output ready is 0 produces no `tx_valid` pulse.
- R9: Reads of offsets 0x10 to 0x1C inside the window return zero. Writes to offsets 0x4 and 0x8 change nothing.
- R10: An access to an address outside the 32-byte window reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Input interrupt request |

## Verification
The bench covers a byte that arrives in the same cycle its predecessor is read. A design that gave the read priority there would silently lose the new byte. It also covers back-to-back arrivals, where an overrun must leave the newest byte in place, not the oldest. The output busy window is measured cycle by cycle: a counter that is off by one shows up as the wrong number of polls returning 0. A write made during that window must not reach the output queue, and the scoreboard catches any stray byte. The bench also tries writes to read-only bits, unmapped offsets and addresses just past the window. An incomplete address decode would alias those accesses onto live registers.

// File: rtl/console_io_ctrl.sv
module console_io_ctrl #(
  parameter int          ADDR_W         = 32,
  parameter int          DATA_W         = 32,
  parameter logic [31:0] BASE_ADDR      = 32'hFFFF_0000,
  parameter int          WIN_BITS       = 5,
  parameter int          TX_BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  localparam int IDX_W = WIN_BITS - 2;
  localparam int CNT_W = $clog2(TX_BUSY_CYCLES + 1);
  localparam logic [IDX_W-1:0] IDX_RXC = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_RXD = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TXC = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_TXD = IDX_W'(3);

  logic             rx_rdy, rx_ien;
  logic [7:0]       rx_buf;
  logic [CNT_W-1:0] tx_cnt;
  logic             tx_rdy;

  wire             hit   = bus_sel && (bus_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
  wire [IDX_W-1:0] idx   = bus_addr[WIN_BITS-1:2];
  wire             rd    = hit && !bus_we;
  wire             wr    = hit && bus_we;
  wire             rd_rx = rd && idx == IDX_RXD;
  wire             wr_cc = wr && idx == IDX_RXC;
  wire             tx_go = wr && idx == IDX_TXD && tx_rdy;
  wire             unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[DATA_W-1:8], bus_wdata[0]};

  assign tx_rdy = (tx_cnt == '0);
  assign irq    = rx_rdy && rx_ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0;
      rx_ien <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (wr_cc) rx_ien <= bus_wdata[1];
      if (rx_valid) begin
        rx_buf <= rx_byte;
        rx_rdy <= 1'b1;
      end else if (rd_rx) begin
        rx_rdy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt   <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= tx_go;
      if (tx_go) begin
        tx_byte <= bus_wdata[7:0];
        tx_cnt  <= CNT_W'(TX_BUSY_CYCLES);
      end else if (!tx_rdy) begin
        tx_cnt <= tx_cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (idx)
        IDX_RXC: bus_rdata = {{(DATA_W-2){1'b0}}, rx_ien, rx_rdy};
        IDX_RXD: bus_rdata = {{(DATA_W-8){1'b0}}, rx_buf};
        IDX_TXC: bus_rdata = {{(DATA_W-1){1'b0}}, tx_rdy};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2
  rx_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_rdy && rx_buf == $past(rx_byte));
  // R3
  rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_valid) |=> !rx_rdy && !irq);
  // R6
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_TXD && tx_rdy) |=> tx_valid && tx_byte == $past(bus_wdata[7:0]) && !tx_rdy);
  // R8
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_TXD && !tx_rdy) |=> !tx_valid);
  // R6
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx > IDX_TXD) |-> bus_rdata == '0);
endmodule

// File: tb/console_io_ctrl_tb.sv
module console_io_ctrl_tb;
  localparam int N = 4;
  localparam logic [31:0] B = 32'hFFFF_0000;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic tx_valid, irq;
  logic [7:0] tx_byte;

  int checks = 0, errors = 0;
  logic [7:0] expq[$];

  console_io_ctrl #(.TX_BUSY_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic push(logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send(logic [7:0] b);
    expq.push_back(b);
    wr(B + 32'hC, {24'hABCDEF, b});
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8: got unexpected byte %h expected no output", tx_byte);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL R6: got %h expected %h", tx_byte, e);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(B, d);        chk("R1 rx ctrl", d, 0);
    rd(B + 8, d);    chk("R1 tx ready", d, 1);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    // R2
    push(8'h5A);
    rd(B, d);        chk("R2 ready", d, 1);
    rd(B + 4, d);    chk("R2 data", d, 32'h5A);
    // R3
    rd(B, d);        chk("R3 cleared", d, 0);
    push(8'h10);
    bus_sel = 1; bus_we = 0; bus_addr = B + 4; rx_valid = 1; rx_byte = 8'h77;
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    rd(B, d);        chk("R3 arrival wins", d, 1);
    rd(B + 4, d);    chk("R3 new byte", d, 32'h77);
    // R4
    push(8'h11);
    push(8'h22);
    rd(B, d);        chk("R4 ready kept", d, 1);
    rd(B + 4, d);    chk("R4 overwrite", d, 32'h22);
    // R5
    wr(B, 32'h3);
    rd(B, d);        chk("R5 enable only", d, 2);
    chk("R5 irq idle", {31'b0, irq}, 0);
    push(8'h33);
    chk("R5 irq set", {31'b0, irq}, 1);
    wr(B, 32'h0);
    chk("R5 irq masked", {31'b0, irq}, 0);
    rd(B, d);        chk("R5 ready held", d, 1);
    wr(B, 32'h2);
    chk("R5 irq again", {31'b0, irq}, 1);
    rd(B + 4, d);
    chk("R5 irq after read", {31'b0, irq}, 0);
    // R6 and R7
    send(8'h41);
    chk("R6 strobe", {31'b0, tx_valid}, 1);
    begin
      int zeros = 0;
      for (int i = 0; i < N + 3; i++) begin
        rd(B + 8, d);
        if (d[0]) break;
        zeros++;
      end
      chk("R7 busy cycles", zeros, N);
    end
    chk("R6 single strobe", {31'b0, tx_valid}, 0);
    // R8
    send(8'h42);
    wr(B + 32'hC, 32'h99);
    repeat (N + 2) @(negedge clk);
    rd(B + 8, d);    chk("R8 ready back", d, 1);
    send(8'h43);
    repeat (N + 2) @(negedge clk);
    // R9
    push(8'h66);
    rd(B + 32'h10, d); chk("R9 unmapped 0x10", d, 0);
    rd(B + 32'h1C, d); chk("R9 unmapped 0x1C", d, 0);
    wr(B + 4, 32'hFF);
    rd(B + 4, d);      chk("R9 data ro", d, 32'h66);
    wr(B + 8, 32'h0);
    rd(B + 8, d);      chk("R9 tx ctrl ro", d, 1);
    // R10
    rd(B + 32'h20, d); chk("R10 outside read", d, 0);
    wr(B + 32'h20, 32'h0);
    rd(B, d);          chk("R10 outside write", d, 2);
    wr(B - 4, 32'h55);
    rd(B + 8, d);      chk("R10 no tx", d, 1);
    repeat (4) @(negedge clk);
    chk("R6 queue drained", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule